// File: doc/BRIEF.md
# Locked-Sequence Bus Hold and Request Arbiter

This block sits beside a processor's bus interface unit. When the instruction decoder reports a lock prefix, the block drives an active-low hold signal. Other bus masters see that signal and leave the bus alone, so the read-modify-write instruction that follows the prefix runs to its end without interruption. The hold is dropped once the last bus cycle of that instruction completes.

Another master asks for the bus by pulsing a request input. The block answers with a one-cycle grant pulse. When the bus is held, the request is not lost: it is stored and granted in the same cycle the hold drops. When the bus is free, a request is granted at the next bus-cycle boundary. A boundary is either a cycle in which a transfer completes or a cycle in which no transfer is in flight. Only one request is ever stored, so several requests made before the grant produce a single grant.

Top module: `buslock_arb`

## Requirements
- R1: After reset, `lock_n_o` is 1 and `gnt_o` is 0.
- R2: A cycle with `pfx_i` = 1 drives `lock_n_o` to 0 from the next cycle on.
- R3: While `lock_n_o` is 0, the hold ends only after a cycle with `done_i` = 1, `last_i` = 1 and `pfx_i` = 0. `lock_n_o` returns to 1 in the following cycle. A completion with `last_i` = 0 keeps the hold.
- R4: `gnt_o` is never 1 while `lock_n_o` is 0. A request made during the hold is recorded, not dropped.
- R5: A request recorded during the hold is granted when the hold ends. `gnt_o` is 1 in the same cycle that `lock_n_o` returns to 1.
- R6: When the bus is not held, a pending or arriving request is granted in the cycle after a boundary. A boundary is `done_i` = 1 or `act_i` = 0. While `act_i` = 1 and `done_i` = 0, the request waits.
- R7: Any number of requests made before a grant are merged into one. The grant is a single pulse of one cycle, and the stored request is cleared by it.
- R8: `pfx_i` = 1 takes precedence over a boundary in the same cycle. No grant follows that cycle, and the request stays stored until the hold ends.
- R9: `pfx_i` = 1 while held, in the same cycle as a final completion, keeps `lock_n_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pfx_i | input | 1 | Lock prefix decoded strobe |
| last_i | input | 1 | The bus cycle in progress is the last of its instruction |
| done_i | input | 1 | Bus cycle completes this clock |
| act_i | input | 1 | A bus cycle is in flight |
| req_i | input | 1 | Request pulse from another bus master |
| lock_n_o | output | 1 | Active-low bus hold |
| gnt_o | output | 1 | One-cycle grant pulse |

## Verification
The hardest case to reach from the ports is a request that collides with the edges of a hold. One form is a request stored during the hold whose grant must line up exactly with the release. Another is a new prefix arriving in the very cycle that would otherwise release the hold or grant the bus. Random stimulus rarely lines these up, so directed sequences place the prefix, the final completion and the request in chosen cycles. A long random run then weights prefixes and final completions heavily, so that holds open and close often with requests scattered across them.

// File: rtl/buslock_pkg.sv
package buslock_pkg;

  // Hold state after this clock: a prefix sets it, a final completion clears it.
  function automatic logic hold_next(logic held, logic pfx, logic fin);
    return pfx | (held & ~fin);
  endfunction

  // A transfer ends that closes its instruction.
  function automatic logic final_done(logic done, logic last);
    return done & last;
  endfunction

  // A grant may be issued at this clock.
  function automatic logic grant_slot(logic held, logic pfx, logic fin,
                                      logic done, logic act);
    logic free_edge;
    logic release_edge;
    free_edge    = ~held & ~pfx & (done | ~act);
    release_edge = held & ~pfx & fin;
    return free_edge | release_edge;
  endfunction

endpackage

// File: rtl/buslock_hold.sv
module buslock_hold
  import buslock_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pfx_i,
  input  logic last_i,
  input  logic done_i,
  output logic held_o,
  output logic fin_o
);
  logic held_q;

  assign fin_o  = final_done(done_i, last_i);
  assign held_o = held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= 1'b0;
    else        held_q <= hold_next(held_q, pfx_i, fin_o);
  end
endmodule

// File: rtl/buslock_reqtrack.sv
module buslock_reqtrack (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic take_i,
  output logic live_o
);
  logic pend_q;

  assign live_o = pend_q | req_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pend_q <= 1'b0;
    else if (take_i) pend_q <= 1'b0;
    else             pend_q <= live_o;
  end
endmodule

// File: rtl/buslock_grant.sv
module buslock_grant
  import buslock_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic live_i,
  input  logic held_i,
  input  logic pfx_i,
  input  logic fin_i,
  input  logic done_i,
  input  logic act_i,
  output logic take_o,
  output logic gnt_o
);
  logic slot;
  logic gnt_q;

  assign slot   = grant_slot(held_i, pfx_i, fin_i, done_i, act_i);
  assign take_o = slot & live_i;
  assign gnt_o  = gnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gnt_q <= 1'b0;
    else        gnt_q <= take_o;
  end
endmodule

// File: rtl/buslock_arb.sv
module buslock_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic pfx_i,
  input  logic last_i,
  input  logic done_i,
  input  logic act_i,
  input  logic req_i,
  output logic lock_n_o,
  output logic gnt_o
);
  logic held;
  logic fin;
  logic live;
  logic take;

  buslock_hold u_hold (
    .clk(clk), .rst_n(rst_n), .pfx_i(pfx_i), .last_i(last_i),
    .done_i(done_i), .held_o(held), .fin_o(fin)
  );

  buslock_reqtrack u_req (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .take_i(take), .live_o(live)
  );

  buslock_grant u_gnt (
    .clk(clk), .rst_n(rst_n), .live_i(live), .held_i(held), .pfx_i(pfx_i),
    .fin_i(fin), .done_i(done_i), .act_i(act_i), .take_o(take), .gnt_o(gnt_o)
  );

  assign lock_n_o = ~held;
endmodule

// File: rtl/buslock_arb_chk.sv
module buslock_arb_chk (
  input logic clk,
  input logic rst_n,
  input logic pfx_i,
  input logic last_i,
  input logic done_i,
  input logic act_i,
  input logic req_i,
  input logic lock_n_o,
  input logic gnt_o,
  input logic live
);
  // R2
  pfx_sets_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pfx_i |=> !lock_n_o);

  // R3
  hold_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_n_o && done_i && last_i && !pfx_i) |=> lock_n_o);

  // R3
  hold_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_n_o && !(done_i && last_i)) |=> !lock_n_o);

  // R4
  no_grant_in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_o |-> lock_n_o);

  // R5
  release_grants_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_n_o && done_i && last_i && !pfx_i && live) |=> gnt_o);

  // R6
  free_boundary_grants_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_n_o && !pfx_i && req_i && (done_i || !act_i)) |=> gnt_o);

  // R8
  pfx_blocks_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pfx_i |=> !gnt_o);

  // R7
  grant_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!live) |=> !gnt_o);
endmodule

bind buslock_arb buslock_arb_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pfx_i(pfx_i), .last_i(last_i), .done_i(done_i),
  .act_i(act_i), .req_i(req_i), .lock_n_o(lock_n_o), .gnt_o(gnt_o), .live(live)
);

// File: tb/buslock_arb_bench.sv
module buslock_arb_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pfx_i = 0, last_i = 0, done_i = 0, act_i = 0, req_i = 0;
  logic lock_n_o, gnt_o;

  int n_chk = 0;
  int n_bad = 0;
  string tag_l = "R1";
  string tag_g = "R1";

  // bench model state
  logic m_hold = 0, m_pend = 0, m_gnt = 0;

  always #2 clk = ~clk;

  buslock_arb u_buslock_arb (
    .clk(clk), .rst_n(rst_n), .pfx_i(pfx_i), .last_i(last_i), .done_i(done_i),
    .act_i(act_i), .req_i(req_i), .lock_n_o(lock_n_o), .gnt_o(gnt_o)
  );

  function automatic logic mdl_hold(logic h, logic p, logic d, logic l);
    if (p) return 1'b1;
    if (h && d && l) return 1'b0;
    return h;
  endfunction

  function automatic logic mdl_grant(logic h, logic pend, logic p, logic d,
                                     logic l, logic a, logic r);
    logic want;
    want = pend || r;
    if (!want || p) return 1'b0;
    if (h) return d && l;
    return d || !a;
  endfunction

  task automatic check(string tag, logic act, logic exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(logic p, logic l, logic d, logic a, logic r);
    logic g;
    @(negedge clk);
    check(tag_l, lock_n_o, ~m_hold, "lock_n_o");
    check(tag_g, gnt_o, m_gnt, "gnt_o");
    pfx_i = p; last_i = l; done_i = d; act_i = a; req_i = r;
    g = mdl_grant(m_hold, m_pend, p, d, l, a, r);
    m_pend = g ? 1'b0 : (m_pend || r);
    m_hold = mdl_hold(m_hold, p, d, l);
    m_gnt  = g;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset values
    check("R1", lock_n_o, 1'b1, "lock_n_o in reset");
    check("R1", gnt_o, 1'b0, "gnt_o in reset");
    rst_n = 1'b1;
    step(0, 0, 0, 1, 0);

    // R2 prefix then R3 non-final completion keeps hold, final releases
    tag_l = "R2"; tag_g = "R2";
    step(1, 0, 0, 1, 0);
    tag_l = "R3"; tag_g = "R3";
    step(0, 0, 1, 1, 0);
    step(0, 0, 0, 1, 0);
    step(0, 1, 1, 1, 0);
    step(0, 0, 0, 1, 0);

    // R4 request during hold is stored; R5 granted at release
    tag_l = "R4"; tag_g = "R4";
    step(1, 0, 0, 1, 0);
    step(0, 0, 0, 1, 1);
    step(0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0);
    tag_l = "R5"; tag_g = "R5";
    step(0, 1, 1, 1, 0);
    step(0, 0, 0, 1, 0);
    step(0, 0, 0, 1, 0);

    // R6 unlocked: waits while busy, grants at boundary
    tag_l = "R6"; tag_g = "R6";
    step(0, 0, 0, 1, 1);
    step(0, 0, 0, 1, 0);
    step(0, 0, 1, 1, 0);
    step(0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 1);
    step(0, 0, 0, 1, 0);

    // R7 several requests merge into one grant
    tag_l = "R7"; tag_g = "R7";
    step(0, 0, 0, 1, 1);
    step(0, 0, 0, 1, 1);
    step(0, 0, 0, 1, 1);
    step(0, 0, 1, 1, 0);
    step(0, 0, 0, 1, 0);
    step(0, 0, 1, 1, 0);
    step(0, 0, 0, 1, 0);

    // R8 prefix beats a boundary; request held until release
    tag_l = "R8"; tag_g = "R8";
    step(1, 0, 1, 0, 1);
    step(0, 0, 0, 0, 0);
    step(0, 1, 1, 1, 0);
    step(0, 0, 0, 1, 0);

    // R9 prefix during final completion keeps hold
    tag_l = "R9"; tag_g = "R9";
    step(1, 0, 0, 1, 0);
    step(1, 1, 1, 1, 1);
    step(0, 0, 0, 1, 0);
    step(0, 1, 1, 1, 0);
    step(0, 0, 0, 1, 0);

    // random mix
    tag_l = "R2/R3"; tag_g = "R5/R6";
    for (int i = 0; i < 4000; i++) begin
      logic p, l, d, a, r;
      p = ($urandom % 8) == 0;
      d = ($urandom % 3) == 0;
      l = ($urandom % 2) == 0;
      a = ($urandom % 4) != 0;
      r = ($urandom % 5) == 0;
      step(p, l, d, a, r);
    end
    step(0, 0, 0, 1, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule